// File: doc/BRIEF.md
# Path-to-Slot Resolver

This block turns a file path, delivered one byte per clock, into the index of a cache slot. While the bytes arrive it runs a 32-bit CRC over them. When the last byte has been taken, the low bits of the CRC select a slot in an on-chip tag table, and the remaining bits are compared with the tag stored there. A matching occupied slot is reported as a hit. An empty slot is claimed for the new path and its index is returned, so that the host can load the file into that location. An occupied slot holding a different tag is reported as a collision, and nothing is allocated.

The host can release a slot at any time through a one-cycle invalidate strobe. The number of index bits is a parameter. The full-size table has 2^21 entries; the default builds a 256-entry table. Paths longer than the length limit (512 bytes by default) are cut at the limit, and the result carries a flag that says so.

Top module: `path_slot_resolver`

## Requirements
- R1: `in_ready` is 1 except in the single cycle after the clock edge that accepts a byte with `in_last` set. A byte offered while `in_ready` is 0 is ignored and contributes nothing to any hash.
- R2: The hash is CRC-32 with polynomial 0x04C11DB7 and seed 0xFFFFFFFF. Each byte is processed MSB first, with no reflection and no final XOR. The slot index is CRC[IDX_W-1:0] and the tag is CRC[31:IDX_W]. For example, the path "123456789" gives index 0xE7 when IDX_W is 8.
- R3: `res_valid` is high for exactly one cycle. It is asserted in the second cycle after the edge that accepts the last byte of a path.
- R4: A lookup that finds its slot empty returns hit=0 and coll=0 with the slot index. It marks the slot occupied with the path's tag.
- R5: A lookup whose slot is occupied with an equal tag returns hit=1, coll=0 and the slot index.
- R6: A lookup whose slot is occupied with a different tag returns hit=0, coll=1 and the slot index, and it leaves the stored entry unchanged.
- R7: Bytes beyond MAX_LEN in a path are left out of the hash, and the result then reports trunc=1. A path of MAX_LEN bytes or fewer reports trunc=0.
- R8: A byte accepted with `in_first` set starts a fresh hash from the seed and discards any partial path. The hash also starts fresh after every result.
- R9: A strobe on `inv_valid` empties slot `inv_index`, so the next lookup that maps there allocates it again. If an allocation writes the same slot on the same edge, the allocation wins.
- R10: After reset, `res_valid` is 0, `in_ready` is 1 and every slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| in_valid | input | 1 | Path byte is offered |
| in_first | input | 1 | Offered byte starts a new path |
| in_last | input | 1 | Offered byte ends the path |
| in_byte | input | 8 | Path byte |
| in_ready | output | 1 | Block can accept a byte |
| inv_valid | input | 1 | Invalidate strobe |
| inv_index | input | IDX_W | Slot to invalidate |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Path found in its slot |
| res_coll | output | 1 | Slot is held by a different tag |
| res_trunc | output | 1 | Path exceeded MAX_LEN bytes |
| res_index | output | IDX_W | Slot index of the path |

## Verification
The result fields are due in the second cycle after the edge that accepts the last byte. `in_ready` drops in the first cycle after that edge and returns in the second. A behavioural model in the bench advances on each rising edge using the same accepted inputs. Every ready and result output is compared with the model on the falling edge, so each value is checked in the exact cycle it is due and not one cycle early or late. Directed checks on known hash values, collisions, truncation and invalidation read the result captured in that same cycle.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFFFFFF;

  typedef enum logic {ST_RECV, ST_LOOK} psr_state_e;

  // Advance the CRC by one byte, MSB first, no reflection.
  function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int b = 7; b >= 0; b--) begin
      fb = c[31] ^ d[b];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c;
  endfunction

endpackage

// File: rtl/psr_rst_sync.sv
module psr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/psr_crc_accum.sv
module psr_crc_accum #(
  parameter int MAX_LEN = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        take,
  input  logic        first,
  input  logic [7:0]  data,
  output logic [31:0] crc,
  output logic        trunc
);
  import psr_pkg::*;

  localparam int CNT_W = $clog2(MAX_LEN + 1);

  logic [31:0]      crc_q, crc_d, base_crc;
  logic [CNT_W-1:0] cnt_q, cnt_d, base_cnt;
  logic             tr_q, tr_d, base_tr;

  always_comb begin
    base_crc = first ? CRC_SEED : crc_q;
    base_cnt = first ? '0 : cnt_q;
    base_tr  = first ? 1'b0 : tr_q;
    crc_d    = crc_q;
    cnt_d    = cnt_q;
    tr_d     = tr_q;
    if (clear) begin
      crc_d = CRC_SEED;
      cnt_d = '0;
      tr_d  = 1'b0;
    end else if (take) begin
      if (base_cnt < CNT_W'(MAX_LEN)) begin
        crc_d = crc_step(base_crc, data);
        cnt_d = base_cnt + CNT_W'(1);
        tr_d  = base_tr;
      end else begin
        crc_d = base_crc;
        cnt_d = base_cnt;
        tr_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_SEED;
      cnt_q <= '0;
      tr_q  <= 1'b0;
    end else if (clear || take) begin
      crc_q <= crc_d;
      cnt_q <= cnt_d;
      tr_q  <= tr_d;
    end
  end

  assign crc   = crc_q;
  assign trunc = tr_q;
endmodule

// File: rtl/psr_slot_table.sv
module psr_slot_table #(
  parameter int IDX_W = 8,
  parameter int TAG_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0] tag_mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic set_g, clr_g, vld_d;
    assign set_g = wr_en  && (wr_idx  == IDX_W'(g));
    assign clr_g = clr_en && (clr_idx == IDX_W'(g));
    always_comb begin
      vld_d = vld_q[g];
      if (set_g)      vld_d = 1'b1;   // allocation beats invalidate
      else if (clr_g) vld_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              vld_q[g] <= 1'b0;
      else if (set_g || clr_g) vld_q[g] <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_mem[wr_idx] <= wr_tag;
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
endmodule

// File: rtl/path_slot_resolver.sv
module path_slot_resolver #(
  parameter int IDX_W   = 8,
  parameter int MAX_LEN = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  input  logic             inv_valid,
  input  logic [IDX_W-1:0] inv_index,
  output logic             res_valid,
  output logic             res_hit,
  output logic             res_coll,
  output logic             res_trunc,
  output logic [IDX_W-1:0] res_index
);
  import psr_pkg::*;

  localparam int TAG_W = 32 - IDX_W;

  logic             rst_n_s;
  psr_state_e       state_q, state_d;
  logic             take, look;
  logic [31:0]      crc;
  logic             trunc;
  logic [IDX_W-1:0] slot_idx;
  logic [TAG_W-1:0] slot_tag, tbl_tag;
  logic             tbl_vld, tag_eq, alloc;

  logic             rv_q, rh_q, rc_q, rt_q;
  logic             rv_d, rh_d, rc_d, rt_d;
  logic [IDX_W-1:0] ri_q, ri_d;

  psr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign look     = (state_q == ST_LOOK);
  assign in_ready = (state_q == ST_RECV);
  assign take     = in_valid && in_ready;

  psr_crc_accum #(.MAX_LEN(MAX_LEN)) u_crc (
    .clk(clk), .rst_n(rst_n_s), .clear(look), .take(take),
    .first(in_first), .data(in_byte), .crc(crc), .trunc(trunc)
  );

  assign slot_idx = crc[IDX_W-1:0];
  assign slot_tag = crc[31:IDX_W];

  psr_slot_table #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tbl (
    .clk(clk), .rst_n(rst_n_s),
    .rd_idx(slot_idx), .rd_valid(tbl_vld), .rd_tag(tbl_tag),
    .wr_en(alloc), .wr_idx(slot_idx), .wr_tag(slot_tag),
    .clr_en(inv_valid), .clr_idx(inv_index)
  );

  assign tag_eq = (tbl_tag == slot_tag);
  assign alloc  = look && !tbl_vld;

  always_comb begin
    state_d = state_q;
    if (look)                 state_d = ST_RECV;
    else if (take && in_last) state_d = ST_LOOK;
  end

  always_comb begin
    rv_d = look;
    rh_d = rh_q;
    rc_d = rc_q;
    rt_d = rt_q;
    ri_d = ri_q;
    if (look) begin
      rh_d = tbl_vld && tag_eq;
      rc_d = tbl_vld && !tag_eq;
      rt_d = trunc;
      ri_d = slot_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_RECV;
      rv_q    <= 1'b0;
      rh_q    <= 1'b0;
      rc_q    <= 1'b0;
      rt_q    <= 1'b0;
      ri_q    <= '0;
    end else begin
      state_q <= state_d;
      rv_q    <= rv_d;
      if (look) begin
        rh_q <= rh_d;
        rc_q <= rc_d;
        rt_q <= rt_d;
        ri_q <= ri_d;
      end
    end
  end

  assign res_valid = rv_q;
  assign res_hit   = rh_q;
  assign res_coll  = rc_q;
  assign res_trunc = rt_q;
  assign res_index = ri_q;
endmodule

// File: rtl/psr_checker.sv
module psr_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_last,
  input logic in_ready,
  input logic res_valid,
  input logic res_hit,
  input logic res_coll
);
  logic last_take;
  assign last_take = in_valid && in_ready && in_last;

  // R1
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> !in_ready);

  // R1
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

  // R3
  result_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |-> ##2 res_valid);

  // R3
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R3
  result_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(!in_ready));

  // R6
  hit_coll_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(res_hit && res_coll));
endmodule

bind path_slot_resolver psr_checker u_psr_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .in_ready(in_ready), .res_valid(res_valid), .res_hit(res_hit),
  .res_coll(res_coll)
);

// File: tb/path_slot_resolver_bench.sv
module path_slot_resolver_bench;
  localparam int IDX_W = 8;
  localparam int DEPTH = 256;
  localparam int MAXL  = 512;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [7:0]       in_byte = 8'h00;
  logic             in_ready;
  logic             inv_valid = 1'b0;
  logic [IDX_W-1:0] inv_index = '0;
  logic             res_valid, res_hit, res_coll, res_trunc;
  logic [IDX_W-1:0] res_index;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  path_slot_resolver #(.IDX_W(IDX_W), .MAX_LEN(MAXL)) u_path_slot_resolver (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_byte(in_byte), .in_ready(in_ready),
    .inv_valid(inv_valid), .inv_index(inv_index), .res_valid(res_valid),
    .res_hit(res_hit), .res_coll(res_coll), .res_trunc(res_trunc),
    .res_index(res_index)
  );

  function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {d, 24'h0};
    for (int k = 0; k < 8; k++)
      r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    return r;
  endfunction

  function automatic logic [31:0] crc_of(input logic [7:0] q[$], input int lim);
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < q.size() && i < lim; i++) c = ref_crc(c, q[i]);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  bit          m_busy;
  logic [31:0] m_crc;
  int          m_cnt;
  bit          m_tr;
  bit          m_vld [DEPTH];
  logic [23:0] m_tag [DEPTH];
  bit          e_valid, e_hit, e_coll, e_tr;
  int          e_idx;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_crc = 32'hFFFFFFFF; m_cnt = 0; m_tr = 0; e_valid = 0;
      for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    end else begin
      e_valid = 0;
      if (m_busy) begin
        int          ix;
        logic [23:0] tg;
        bit          al;
        ix = int'(m_crc % DEPTH);
        tg = m_crc[31:8];
        e_valid = 1; e_idx = ix; e_tr = m_tr;
        e_hit = m_vld[ix] && (m_tag[ix] == tg);
        e_coll = m_vld[ix] && (m_tag[ix] != tg);
        al = !m_vld[ix];
        if (inv_valid) m_vld[inv_index] = 0;
        if (al) begin m_vld[ix] = 1; m_tag[ix] = tg; end
        m_busy = 0; m_crc = 32'hFFFFFFFF; m_cnt = 0; m_tr = 0;
      end else begin
        if (inv_valid) m_vld[inv_index] = 0;
        if (in_valid) begin
          if (in_first) begin m_crc = 32'hFFFFFFFF; m_cnt = 0; m_tr = 0; end
          if (m_cnt < MAXL) begin m_crc = ref_crc(m_crc, in_byte); m_cnt++; end
          else m_tr = 1;
          if (in_last) m_busy = 1;
        end
      end
    end
  end

  // Per-cycle comparison and result capture
  bit               got;
  bit               c_hit, c_coll, c_tr;
  logic [IDX_W-1:0] c_idx;

  always @(negedge clk) begin
    if (!rst_n) begin
      check(res_valid == 1'b0, "R10 res_valid in reset", res_valid, 0);
      check(in_ready == 1'b1, "R10 in_ready in reset", in_ready, 1);
    end else begin
      check(in_ready == !m_busy, "R1 in_ready", in_ready, !m_busy);
      check(res_valid == e_valid, "R3 res_valid", res_valid, e_valid);
      if (res_valid && e_valid) begin
        check(res_index == e_idx[7:0], "R2 res_index", res_index, e_idx);
        check(res_hit == e_hit, "R5 res_hit", res_hit, e_hit);
        check(res_coll == e_coll, "R6 res_coll", res_coll, e_coll);
        check(res_trunc == e_tr, "R7 res_trunc", res_trunc, e_tr);
      end
      if (res_valid) begin
        got = 1; c_hit = res_hit; c_coll = res_coll; c_tr = res_trunc; c_idx = res_index;
      end
    end
  end

  task automatic send_path(input logic [7:0] q[$], input bit with_first, input bit with_last,
                           input bit junk);
    got = 0;
    for (int i = 0; i < q.size(); i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1; in_byte = q[i];
      in_first = with_first && (i == 0);
      in_last  = with_last && (i == q.size() - 1);
    end
    @(negedge clk);
    if (junk) begin
      in_valid = 1; in_byte = 8'hFF; in_first = 0; in_last = 1;
      @(negedge clk);
    end
    in_valid = 0; in_first = 0; in_last = 0;
  endtask

  task automatic wait_result();
    int n;
    n = 0;
    while (!got && n < 20) begin @(negedge clk); #1; n++; end
    check(got, "R3 result arrived", got, 1);
    got = 0;
  endtask

  // Watchdog
  initial begin
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0]  p0[$], pc[$], pl[$], pp[$], pz[$];
    logic [31:0] c0, cc, cl;
    bit          found, long_coll;
    string       s;
    s = "123456789";
    for (int i = 0; i < s.len(); i++) p0.push_back(s[i]);
    c0 = crc_of(p0, MAXL);
    found = 0;
    for (int n = 0; n < 65536 && !found; n++) begin
      pc = {};
      pc.push_back(n[15:8]); pc.push_back(n[7:0]);
      cc = crc_of(pc, MAXL);
      if (cc[7:0] == c0[7:0] && cc[31:8] != c0[31:8]) found = 1;
    end
    for (int i = 0; i < 600; i++) pl.push_back(8'(i * 7 + 3));
    for (int i = 0; i < MAXL; i++) pp.push_back(pl[i]);
    cl = crc_of(pl, MAXL);
    pz.push_back(8'h7A); pz.push_back(8'h7A); pz.push_back(8'h7A);

    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 R4: known vector, empty slot allocates
    send_path(p0, 1, 1, 0); wait_result();
    check(c_idx == 8'hE7, "R2 index of 123456789", c_idx, 8'hE7);
    check(!c_hit && !c_coll, "R4 first lookup misses", {c_hit, c_coll}, 0);

    // R5: repeat hits
    send_path(p0, 1, 1, 0); wait_result();
    check(c_hit && c_idx == 8'hE7, "R5 repeat hits", {c_hit, c_idx}, {1'b1, 8'hE7});

    // R6: different tag, same slot
    check(found, "R6 collider found", found, 1);
    send_path(pc, 1, 1, 0); wait_result();
    check(c_coll && !c_hit && c_idx == 8'hE7, "R6 collision", {c_coll, c_hit}, 2'b10);
    send_path(p0, 1, 1, 0); wait_result();
    check(c_hit, "R6 entry unchanged", c_hit, 1);

    // R9: invalidate then reallocate
    @(negedge clk); inv_valid = 1; inv_index = 8'hE7;
    @(negedge clk); inv_valid = 0;
    send_path(pc, 1, 1, 0); wait_result();
    check(!c_hit && !c_coll, "R9 miss after invalidate", {c_hit, c_coll}, 0);
    send_path(pc, 1, 1, 0); wait_result();
    check(c_hit, "R9 realloc holds new tag", c_hit, 1);

    // R8: partial path discarded by in_first
    send_path(pz, 1, 0, 0);
    send_path(p0, 1, 1, 0); wait_result();
    check(c_idx == 8'hE7 && c_coll, "R8 restart on in_first", c_idx, 8'hE7);

    // R1: byte offered while busy is ignored; next path starts from seed without in_first
    send_path(p0, 1, 1, 1); wait_result();
    check(c_idx == 8'hE7, "R1 busy-cycle byte", c_idx, 8'hE7);
    send_path(p0, 0, 1, 0); wait_result();
    check(c_idx == 8'hE7 && c_coll, "R1 busy byte not hashed / R8 seed after result",
          c_idx, 8'hE7);

    // R7: long path truncated, exact-limit path not
    send_path(pl, 1, 1, 0); wait_result();
    long_coll = c_coll;
    check(c_tr, "R7 trunc flag on long path", c_tr, 1);
    check(c_idx == cl[7:0], "R7 hash of first MAX_LEN bytes", c_idx, cl[7:0]);
    send_path(pp, 1, 1, 0); wait_result();
    check(!c_tr, "R7 no trunc at limit", c_tr, 0);
    check(c_hit == !long_coll, "R7 prefix matches truncated path", c_hit, !long_coll);

    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule